// File: doc/BRIEF.md
# Serial Control Port Slave

This block is the peripheral end of a four-wire serial control link. A host frames each transaction by pulling an active-low select line low. It then clocks in a command byte on a serial clock. Depending on that command, the host sends zero, one or two further bytes to the block, or reads one or two reply bytes back from it. Every byte travels most significant bit first. The block samples the data line on rising clock edges only. Because of that, the host may park the clock at either level between transactions. All four bus lines are oversampled by the system clock through two-flop synchronisers. The system clock must run at least eight times faster than the shortest serial clock period.

A write never takes effect in the middle of a transfer. The block stores the command and payload bits as they arrive. It acts on them only when the select line returns high, and only if the bit count is exactly what the command requires. The register bank behind the port is a small test bank of byte-wide and word-wide registers.

The serial link carries no back-pressure of its own: the host sets the pace, and the block accepts every bit on the rising edge that delivers it. For that reason the edge of the block has no valid/ready pair, and all pins are plain. The reply line has a separate output-enable pin so that a pad driver can make it high impedance.

Top module: `scb_slave`

## Requirements
- R1: Command and write-payload bits are taken from `sdi_i` on rising edges of `sclk_i` while `csn_i` is low, most significant bit first.
- R2: The command code sets the payload length. 0x10+n (n below 4) writes one byte to byte register n. 0x20+m (m below 2) writes two bytes to word register m, with the high byte sent first.
- R3: Reading returns data most significant bit first. 0x30+n returns byte register n as one reply byte. 0x40+m returns word register m as two bytes, high byte first. The first reply bit is on `sdo_o` before the first rising edge after the command byte.
- R4: A write is applied only when `csn_i` rises, and only if the total bit count equals 8 plus 8 times the payload bytes. Any other count leaves every register unchanged: a partial byte, a missing byte or extra bits.
- R5: Transfers work whether `sclk_i` rests high or low around the select window.
- R6: `sdo_oe_o` is low while `csn_i` is high. Within a selected transaction it rises only after `sclk_i` has been seen low, and it returns low after `csn_i` rises.
- R7: Command 0x01 with no payload clears every byte and word register when `csn_i` rises.
- R8: Command codes outside those listed above are ignored and change no register. This includes write codes whose register index is out of range.
- R9: After reset all registers read zero and `sdo_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the fastest serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Active-low transaction select |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Command and write data from the host |
| sdo_o | output | 1 | Reply data to the host |
| sdo_oe_o | output | 1 | Reply pad driver enable, high to drive |

## Verification
The write-then-read table alternates the resting level of the serial clock and mixes byte and word registers. This makes a polarity fault, or a swapped byte order in word transfers, show up as a wrong read-back. The data values include single set bits at either end, as well as all-ones and alternating patterns, so that reversed bit order and an off-by-one shift can be told apart. Directed transfers then send truncated, short, over-long and unknown-code writes. Each is followed by a read-back of the register it could have touched. The output enable is checked both before and after the first clock low phase, and the clear command is tried after the bank has been filled.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int N_REG8  = 4;
  localparam int N_REG16 = 2;
  localparam int IDX_W   = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLEAR,
    OP_WR8,
    OP_WR16,
    OP_RD8,
    OP_RD16
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  // Command code map: high nibble selects the kind, low nibble the register.
  function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] code);
    cmd_t d;
    d.op  = OP_NONE;
    d.idx = code[IDX_W-1:0];
    if (code == 8'h01)
      d.op = OP_CLEAR;
    else if (code[7:4] == 4'h1 && int'(code[3:0]) < N_REG8)
      d.op = OP_WR8;
    else if (code[7:4] == 4'h2 && int'(code[3:0]) < N_REG16)
      d.op = OP_WR16;
    else if (code[7:4] == 4'h3 && int'(code[3:0]) < N_REG8)
      d.op = OP_RD8;
    else if (code[7:4] == 4'h4 && int'(code[3:0]) < N_REG16)
      d.op = OP_RD16;
    return d;
  endfunction
endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scb_frame.sv
module scb_frame
  import scb_pkg::*;
#(
  parameter int MAX_BITS = BYTE_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              cmd_load,
  output logic [BYTE_W-1:0] cmd_next,
  output logic              pay_shift,
  output logic              commit,
  output op_e               wr_op,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(MAX_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(BYTE_W + WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sclk_q, csn_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] cmd_sh;
  logic [WORD_W-1:0] data_sh;
  logic              rise, sel_fall, sel_rise, len_ok;
  logic [CNT_W-1:0]  need;
  cmd_t              dec;

  always_comb begin
    rise      = sclk_s & ~sclk_q & ~csn_s & ~csn_q;
    sel_fall  = csn_q & ~csn_s;
    sel_rise  = ~csn_q & csn_s;
    cmd_load  = rise && (bit_cnt == CNT_LAST);
    cmd_next  = {cmd_sh[BYTE_W-2:0], sdi_s};
    pay_shift = rise && (bit_cnt >= CNT_CMD);
    dec       = decode_cmd(cmd_sh);
    case (dec.op)
      OP_CLEAR: need = CNT_CMD;
      OP_WR8:   need = CNT_ONE;
      OP_WR16:  need = CNT_TWO;
      default:  need = '0;
    endcase
    len_ok = (dec.op inside {OP_CLEAR, OP_WR8, OP_WR16}) && (bit_cnt == need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      csn_q   <= 1'b1;
      bit_cnt <= '0;
      cmd_sh  <= '0;
      data_sh <= '0;
      commit  <= 1'b0;
      wr_op   <= OP_NONE;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
      commit <= sel_rise && len_ok;
      if (sel_rise) begin
        wr_op   <= dec.op;
        wr_idx  <= dec.idx;
        wr_data <= data_sh;
      end
      if (sel_fall) begin
        bit_cnt <= '0;
        cmd_sh  <= '0;
        data_sh <= '0;
      end else if (rise) begin
        if (bit_cnt < CNT_CMD) cmd_sh <= cmd_next;
        else                   data_sh <= {data_sh[WORD_W-2:0], sdi_s};
        if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R4: a new transaction starts counting from zero
  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_s) |=> (bit_cnt == '0));
  // R4: a commit only follows the select line returning high
  p_commit_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(csn_s) && csn_q));
  // R3: reply is loaded only while selected
  p_load_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |-> !csn_s);
endmodule

// File: rtl/scb_regs.sv
module scb_regs
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               wr_op,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] rd_code,
  output logic [WORD_W-1:0] rd_word
);
  logic [N_REG8-1:0][BYTE_W-1:0]  reg8;
  logic [N_REG16-1:0][WORD_W-1:0] reg16;
  logic [N_REG8-1:0]              we8;
  logic [N_REG16-1:0]             we16;
  logic                           clr;
  cmd_t                           rd;

  assign clr = commit && (wr_op == OP_CLEAR);

  for (genvar g = 0; g < N_REG8; g++) begin : g_b
    assign we8[g] = commit && (wr_op == OP_WR8) && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg8[g] <= '0;
      else if (clr)    reg8[g] <= '0;
      else if (we8[g]) reg8[g] <= wr_data[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < N_REG16; g++) begin : g_w
    assign we16[g] = commit && (wr_op == OP_WR16) && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       reg16[g] <= '0;
      else if (clr)     reg16[g] <= '0;
      else if (we16[g]) reg16[g] <= wr_data;
    end
  end

  always_comb begin
    rd      = decode_cmd(rd_code);
    rd_word = '0;
    for (int i = 0; i < N_REG8; i++)
      if (rd.op == OP_RD8 && rd.idx == IDX_W'(i)) rd_word = {reg8[i], {BYTE_W{1'b0}}};
    for (int i = 0; i < N_REG16; i++)
      if (rd.op == OP_RD16 && rd.idx == IDX_W'(i)) rd_word = reg16[i];
  end

  // R2: at most one register is written per commit
  p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we8, we16}));
  // R7: the clear command empties the whole bank
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (reg8 == '0 && reg16 == '0));
  // R4: without a commit the bank holds its value
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(reg8) && $stable(reg16)));
endmodule

// File: rtl/scb_shift_out.sv
module scb_shift_out
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              sdo,
  output logic              oe
);
  logic [WORD_W-1:0] rsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsh <= '0;
      oe  <= 1'b0;
    end else if (csn_s) begin
      rsh <= '0;
      oe  <= 1'b0;
    end else begin
      if (!sclk_s) oe <= 1'b1;
      if (load)       rsh <= load_word;
      else if (shift) rsh <= {rsh[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo = oe & rsh[WORD_W-1];

  // R6: the driver is only enabled after a selected cycle
  p_oe_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !$past(csn_s));
  // R6: enable first appears only after a low clock phase
  p_oe_after_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !$past(sclk_s));
endmodule

// File: rtl/scb_slave.sv
module scb_slave
  import scb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic csn_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              csn_s, sclk_s, sdi_s;
  logic              cmd_load, pay_shift, commit;
  logic [BYTE_W-1:0] cmd_next;
  op_e               wr_op;
  logic [IDX_W-1:0]  wr_idx;
  logic [WORD_W-1:0] wr_data, rd_word;

  scb_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({csn_i, sclk_i, sdi_i}),
    .q({csn_s, sclk_s, sdi_s})
  );

  scb_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .cmd_load(cmd_load), .cmd_next(cmd_next), .pay_shift(pay_shift),
    .commit(commit), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  scb_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .wr_op(wr_op), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_code(cmd_next), .rd_word(rd_word)
  );

  scb_shift_out u_out (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sclk_s(sclk_s),
    .load(cmd_load), .load_word(rd_word), .shift(pay_shift),
    .sdo(sdo_o), .oe(sdo_oe_o)
  );
endmodule

// File: tb/tb_scb_slave.sv
module tb_scb_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic oe_all;

  always #(CLK_P/2) clk = ~clk;

  scb_slave dut (.clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk),
                 .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  typedef struct packed {
    logic        idle_hi;
    logic [7:0]  wcmd;
    logic [15:0] wdata;
    logic [7:0]  rcmd;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h10, 16'h00A5, 8'h30, 16'hA500},
    '{1'b1, 8'h13, 16'h003C, 8'h33, 16'h3C00},
    '{1'b0, 8'h20, 16'h1234, 8'h40, 16'h1234},
    '{1'b1, 8'h21, 16'h80FE, 8'h41, 16'h80FE},
    '{1'b1, 8'h11, 16'h0081, 8'h31, 16'h8100},
    '{1'b0, 8'h12, 16'h007E, 8'h32, 16'h7E00},
    '{1'b0, 8'h21, 16'h0001, 8'h41, 16'h0001},
    '{1'b1, 8'h10, 16'h00FF, 8'h30, 16'hFF00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel(input logic idle_hi);
    sclk = idle_hi;
    wclk(4);
    csn = 1'b0;
    wclk(HALF);
    oe_all = 1'b1;
  endtask

  task automatic bits(input logic [7:0] v, input int n, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sclk = 1'b0;
      sdi  = v[i];
      wclk(HALF);
      got[i] = sdo;
      oe_all = oe_all & sdo_oe;
      sclk = 1'b1;
      wclk(HALF);
    end
  endtask

  task automatic desel(input logic idle_hi);
    if (!idle_hi) begin
      sclk = 1'b0;
      wclk(HALF);
    end
    csn = 1'b1;
    wclk(8);
  endtask

  task automatic wr(input logic idle_hi, input logic [7:0] c, input int nb,
                    input logic [15:0] d);
    logic [7:0] g;
    sel(idle_hi);
    bits(c, 8, g);
    if (nb == 2) bits(d[15:8], 8, g);
    if (nb >= 1) bits(d[7:0], 8, g);
    desel(idle_hi);
  endtask

  task automatic rd(input logic idle_hi, input logic [7:0] c, output logic [15:0] v);
    logic [7:0] g1, g2, g;
    sel(idle_hi);
    bits(c, 8, g);
    bits(8'h00, 8, g1);
    g2 = 8'h00;
    if (c[7:4] == 4'h4) bits(8'h00, 8, g2);
    desel(idle_hi);
    v = {g1, g2};
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  g;
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    // R9: reset state
    chk("R9 oe after reset", {31'd0, sdo_oe}, 32'd0);
    rd(1'b0, 8'h31, v);
    chk("R9 byte reg zero", {16'd0, v}, 32'h0000);
    rd(1'b1, 8'h40, v);
    chk("R9 word reg zero", {16'd0, v}, 32'h0000);

    // R1 R2 R3 R5: write then read back, alternating clock resting level
    foreach (VECS[k]) begin
      wr(VECS[k].idle_hi, VECS[k].wcmd, (VECS[k].wcmd[7:4] == 4'h2) ? 2 : 1, VECS[k].wdata);
      rd(~VECS[k].idle_hi, VECS[k].rcmd, v);
      chk("R1 R2 R3 R5 readback", {16'd0, v}, {16'd0, VECS[k].exp});
      chk("R6 oe during reply", {31'd0, oe_all}, 32'd1);
    end

    // R4: partial byte discarded
    sel(1'b0); bits(8'h10, 8, g); bits(8'h55, 5, g); desel(1'b1);
    rd(1'b0, 8'h30, v);
    chk("R4 partial byte", {16'd0, v}, 32'hFF00);
    // R4: missing second byte discarded
    wr(1'b1, 8'h20, 1, 16'h00AA);
    rd(1'b1, 8'h40, v);
    chk("R4 short payload", {16'd0, v}, 32'h1234);
    // R4: extra byte discarded
    wr(1'b0, 8'h11, 2, 16'h5A5A);
    rd(1'b0, 8'h31, v);
    chk("R4 extra bits", {16'd0, v}, 32'h8100);
    // R8: unknown code and out-of-range index
    wr(1'b0, 8'h55, 1, 16'h0000);
    rd(1'b0, 8'h32, v);
    chk("R8 unknown code", {16'd0, v}, 32'h7E00);
    wr(1'b1, 8'h14, 1, 16'h0011);
    rd(1'b1, 8'h30, v);
    chk("R8 index out of range", {16'd0, v}, 32'hFF00);
    wr(1'b0, 8'h22, 2, 16'h9999);
    rd(1'b0, 8'h41, v);
    chk("R8 word index out of range", {16'd0, v}, 32'h0001);

    // R6: enable timing around selection
    sclk = 1'b1; wclk(4); csn = 1'b0; wclk(HALF);
    chk("R6 no enable before low phase", {31'd0, sdo_oe}, 32'd0);
    sclk = 1'b0; wclk(HALF);
    chk("R6 enable after low phase", {31'd0, sdo_oe}, 32'd1);
    sclk = 1'b1; wclk(HALF);
    csn = 1'b1; wclk(6);
    chk("R6 released after deselect", {31'd0, sdo_oe}, 32'd0);

    // R7: general clear
    wr(1'b1, 8'h01, 0, 16'h0000);
    rd(1'b0, 8'h41, v);
    chk("R7 word cleared", {16'd0, v}, 32'h0000);
    rd(1'b1, 8'h33, v);
    chk("R7 byte cleared", {16'd0, v}, 32'h0000);
    rd(1'b0, 8'h30, v);
    chk("R7 byte0 cleared", {16'd0, v}, 32'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule